// File: doc/BRIEF.md
# ADC Sample/Convert Sequencing Controller

This block sequences the two phases of an analog-to-digital conversion: a sampling phase, during which the sample-and-hold tracks its input, and a conversion phase, which is started by a one-cycle pulse to the converter and ended by the converter's completion strobe. Software drives the block through a 16-bit control word that it writes and reads back. The word holds an enable, a stop-in-idle option, an auto-start option, a software sample bit, a completion flag and a 4-bit select that chooses what ends sampling.

Sampling can be ended in four ways. Software can clear the sample bit. A rising edge on one of five external event lines can end it; these lines come from an interrupt pin, three timers and a capacitance-measurement unit. An internal counter can end it after a programmable number of cycles. When auto-start is set, hardware sets the sample bit again as soon as a conversion completes, so conversions repeat without software. An idle input, combined with the stop-in-idle option, freezes the sequence until the idle input drops.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `rd_data_o` reads 0x0400 and both `sample_o` and `conv_start_o` are 0.
- R2: Readback bit positions are: bit 15 enable, bit 13 stop-in-idle, bits 7:4 select, bit 2 auto-start, bit 1 sample, bit 0 done. Bit 10 always reads 1, and bits 14, 12:11, 9:8 and 3 always read 0, whatever value is written.
- R3: While enable reads 0, writes of the sample bit, trigger edges and the counter have no effect, and `conv_start_o` stays 0. Writing enable to 0 forces `sample_o` low in the next cycle and clears the sample bit one cycle later. A write that sets the sample bit acts only if enable was already 1 before that write.
- R4: With select 0, a write that clears the sample bit while sampling ends sampling. In the next cycle `sample_o` is 0, `conv_start_o` is 1 and done reads 0.
- R5: Selects 1 to 5 end sampling on a rising edge of `trig_i[select-1]`: index 0 is the interrupt pin, 1 to 3 are timers and 4 is the capacitance unit. `conv_start_o` rises one cycle after the edge. Edges on other lines, a line held high, and edges while not sampling are ignored.
- R6: With select 7, `sample_o` stays high for exactly `smp_len_i` cycles, or 1 cycle when `smp_len_i` is 0. `conv_start_o` pulses in the first cycle after that.
- R7: Selects 6 and 8 to 15 never produce `conv_start_o`. With any select other than 0, writing the sample bit to 0 ends sampling without starting a conversion.
- R8: A `conv_done_i` strobe during conversion sets done in the next cycle. With auto-start 0 the block then holds, with the sample bit at 0. A strobe outside conversion is ignored.
- R9: With auto-start 1, the sample bit and `sample_o` read 1 in the cycle after a completion strobe.
- R10: Writing 0 to bit 0 clears done, and writing 1 to it never sets done. When a completion strobe and a clearing write fall in the same cycle, done reads 1 afterwards.
- R11: With stop-in-idle 1 and `idle_i` high, `sample_o` is 0, and the sample bit, the counter progress, trigger edges and completion strobes are frozen or ignored. Operation resumes when `idle_i` drops. With stop-in-idle 0, `idle_i` has no effect.
- R12: `conv_start_o` is never high for two cycles in a row, and done reads 0 in the cycle where it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word write data |
| rd_data_o | output | 16 | Control word readback |
| trig_i | input | NUM_EXT (5) | External event lines |
| idle_i | input | 1 | Device idle indication |
| smp_len_i | input | CNT_W (5) | Sampling length for the internal counter, in cycles |
| conv_done_i | input | 1 | Completion strobe from the converter |
| sample_o | output | 1 | Sample-and-hold sampling enable |
| conv_start_o | output | 1 | One-cycle conversion start pulse |

## Verification
Two things can act on the done flag in the same clock edge. The converter's completion strobe sets it, and a software write with bit 0 at 0 clears it. The bench drives both on the same edge while a conversion is in flight and requires done to read 1 afterwards. Auto-start re-arming is also checked in the cycle right after completion, by requiring the sample bit and `sample_o` to be high together with done.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W    = 16;
  localparam int SEL_W    = 4;
  localparam int BIT_EN   = 15;
  localparam int BIT_SIDL = 13;
  localparam int BIT_RSV  = 10;
  localparam int SEL_LSB  = 4;
  localparam int BIT_ASAM = 2;
  localparam int BIT_SAMP = 1;
  localparam int BIT_DONE = 0;

  localparam logic [SEL_W-1:0] SRC_SW   = 4'd0;
  localparam logic [SEL_W-1:0] SRC_AUTO = 4'd7;

  typedef struct packed {
    logic             en;
    logic             sidl;
    logic [SEL_W-1:0] sel;
    logic             asam;
  } cfg_t;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int NUM_EXT = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               fire_o
);
  logic [NUM_EXT-1:0] prev_q;
  logic [NUM_EXT-1:0] rise;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= ext_i[g];
    end
    assign rise[g] = ext_i[g] & ~prev_q[g];
  end

  // select value k+1 picks line k
  always_comb begin
    fire_o = 1'b0;
    for (int k = 0; k < NUM_EXT; k++)
      if (sel_i == SEL_W'(k + 1)) fire_o = rise[k];
  end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last     = (len_i == '0) ? '0 : len_i - 1'b1;
  assign expire_o = run_i & (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_EXT = 5,
  parameter int CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic [NUM_EXT-1:0] trig_i,
  input  logic               idle_i,
  input  logic [CNT_W-1:0]   smp_len_i,
  input  logic               conv_done_i,
  output logic               sample_o,
  output logic               conv_start_o
);
  cfg_t cfg_q;
  logic samp_q, busy_q, done_q, start_q;
  logic halt, live;
  logic trig_fire, tmr_expire;
  logic wr_samp, sw_end, sw_abort, sw_start;
  logic end_evt, complete;
  logic unused_wr;

  assign unused_wr = ^{wr_data_i[14], wr_data_i[12:8], wr_data_i[3]};

  assign halt    = cfg_q.sidl & idle_i;
  assign live    = cfg_q.en & ~halt;
  assign wr_samp = wr_data_i[BIT_SAMP];

  adc_seq_trig #(.NUM_EXT(NUM_EXT)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (trig_i),
    .sel_i  (cfg_q.sel),
    .fire_o (trig_fire)
  );

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (~samp_q),
    .run_i    (live & samp_q & (cfg_q.sel == SRC_AUTO)),
    .len_i    (smp_len_i),
    .expire_o (tmr_expire)
  );

  // sample-bit writes are judged against the select in force before the write
  assign sw_end   = wr_en_i & samp_q & ~wr_samp & (cfg_q.sel == SRC_SW);
  assign sw_abort = wr_en_i & samp_q & ~wr_samp & (cfg_q.sel != SRC_SW);
  assign sw_start = wr_en_i & wr_samp & ~samp_q & ~busy_q;
  assign end_evt  = live & (sw_end | (samp_q & (trig_fire | tmr_expire)));
  assign complete = live & busy_q & conv_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      samp_q  <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= end_evt;
      if (wr_en_i) begin
        cfg_q.en   <= wr_data_i[BIT_EN];
        cfg_q.sidl <= wr_data_i[BIT_SIDL];
        cfg_q.sel  <= wr_data_i[SEL_LSB +: SEL_W];
        cfg_q.asam <= wr_data_i[BIT_ASAM];
      end
      if (!cfg_q.en) begin
        samp_q <= 1'b0;
        busy_q <= 1'b0;
      end else if (!halt) begin
        if (end_evt) begin
          samp_q <= 1'b0;
          busy_q <= 1'b1;
        end else if (complete) begin
          busy_q <= 1'b0;
          samp_q <= cfg_q.asam;
        end else if (sw_abort) begin
          samp_q <= 1'b0;
        end else if (sw_start) begin
          samp_q <= 1'b1;
        end
      end
    end
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            done_q <= 1'b0;
    else if (complete)                      done_q <= 1'b1;
    else if (end_evt)                       done_q <= 1'b0;
    else if (wr_en_i && !wr_data_i[BIT_DONE]) done_q <= 1'b0;
  end

  always_comb begin
    rd_data_o                     = '0;
    rd_data_o[BIT_EN]             = cfg_q.en;
    rd_data_o[BIT_SIDL]           = cfg_q.sidl;
    rd_data_o[BIT_RSV]            = 1'b1;
    rd_data_o[SEL_LSB +: SEL_W]   = cfg_q.sel;
    rd_data_o[BIT_ASAM]           = cfg_q.asam;
    rd_data_o[BIT_SAMP]           = samp_q;
    rd_data_o[BIT_DONE]           = done_q;
  end

  assign sample_o     = samp_q & live;
  assign conv_start_o = start_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] rd_data_o,
  input logic        idle_i,
  input logic        conv_done_i,
  input logic        sample_o,
  input logic        conv_start_o
);
  // R12
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  // R12
  start_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (!rd_data_o[0] && !sample_o));

  // R3
  off_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[15] |=> !conv_start_o);

  // R8
  done_from_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[0]) |-> $past(conv_done_i));

  // R7
  bad_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7:4] == 4'd6 || rd_data_o[7]) |=> !conv_start_o);

  // R11
  idle_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[15] && rd_data_o[13] && idle_i) |=> $stable(rd_data_o[1]));
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_data_o    (rd_data_o),
  .idle_i       (idle_i),
  .conv_done_i  (conv_done_i),
  .sample_o     (sample_o),
  .conv_start_o (conv_start_o)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int PERIOD = 10;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic [4:0]  trig_i = '0;
  logic        idle_i = 1'b0;
  logic [4:0]  smp_len_i = 5'd4;
  logic        conv_done_i = 1'b0;
  logic        sample_o;
  logic        conv_start_o;

  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   ended = 1'b0;
  exp_t sb_q[$];

  adc_seq_ctrl u0 (.*);

  always #(PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [15:0] cw(bit en, bit sidl, int sel, bit asam, bit samp, bit dn);
    logic [15:0] w;
    w = '0;
    w[15] = en; w[13] = sidl; w[7:4] = sel[3:0]; w[2] = asam; w[1] = samp; w[0] = dn;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic expect_start(int c, string tag);
    exp_t e;
    e.cyc = c; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic pulse_done();
    @(negedge clk_i); conv_done_i = 1'b1;
    @(negedge clk_i); conv_done_i = 1'b0;
  endtask

  task automatic pulse_trig(int k, bit hit, string tag);
    @(negedge clk_i); trig_i[k] = 1'b1;
    if (hit) expect_start(cyc + 1, tag);
    @(negedge clk_i); trig_i[k] = 1'b0;
  endtask

  // monitor: every start pulse must match the head of the scoreboard
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && conv_start_o) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected start actual=%0d expected=none", cyc);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.cyc != cyc) begin
          fails++;
          $display("FAIL %s start cycle actual=%0d expected=%0d", e.tag, cyc, e.cyc);
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    chk("R1 readback", rd_data_o, 16'h0400);
    chk("R1 sample", sample_o, 0);
    chk("R1 start", conv_start_o, 0);

    // R2: all-ones write, enable was 0 so sample ignored, done not settable
    wr(16'hFFFF);
    chk("R2 layout", rd_data_o, 16'hA4F4);
    wr(16'h0000);
    chk("R2 cleared", rd_data_o, 16'h0400);

    // R3: disabled
    wr(cw(0, 0, 0, 0, 1, 0));
    chk("R3 samp write off", rd_data_o[1], 0);
    wr(cw(0, 0, 1, 0, 0, 0));
    pulse_trig(0, 0, "R3");
    chk("R3 trig off", sample_o, 0);

    // R4: software end
    wr(cw(1, 0, 0, 0, 0, 0));
    wr(cw(1, 0, 0, 0, 1, 0));
    chk("R4 sampling", sample_o, 1);
    wr(cw(1, 0, 0, 0, 0, 0));
    expect_start(cyc, "R4");
    chk("R4 sample low", sample_o, 0);
    chk("R4 done low", rd_data_o[0], 0);
    step(1);
    chk("R12 single pulse", conv_start_o, 0);
    pulse_done();
    chk("R8 done set", rd_data_o[0], 1);
    chk("R8 hold no asam", rd_data_o[1], 0);
    wr(cw(1, 0, 0, 0, 0, 0));
    chk("R10 sw clear", rd_data_o[0], 0);
    wr(cw(1, 0, 0, 0, 0, 1));
    chk("R10 write1 no set", rd_data_o[0], 0);
    pulse_done();
    chk("R8 stray strobe", rd_data_o[0], 0);

    // R5: each external line, wrong line first
    for (int k = 0; k < 5; k++) begin
      wr(cw(1, 0, k + 1, 0, 1, 0));
      pulse_trig((k + 1) % 5, 0, "R5");
      chk("R5 other line ignored", sample_o, 1);
      pulse_trig(k, 1, "R5");
      chk("R5 ended", sample_o, 0);
      pulse_done();
    end
    // R5: level and edge outside sampling
    wr(cw(1, 0, 1, 0, 0, 0));
    @(negedge clk_i); trig_i[0] = 1'b1;
    wr(cw(1, 0, 1, 0, 1, 0));
    step(5);
    chk("R5 level ignored", sample_o, 1);
    @(negedge clk_i); trig_i[0] = 1'b0;
    pulse_trig(0, 1, "R5");
    pulse_done();

    // R6: internal counter
    smp_len_i = 5'd4;
    wr(cw(1, 0, 7, 0, 1, 0));
    expect_start(cyc + 4, "R6");
    begin
      int n = 0;
      while (sample_o && n < 100) begin n++; @(negedge clk_i); end
      chk("R6 length 4", n, 4);
    end
    pulse_done();
    smp_len_i = 5'd0;
    wr(cw(1, 0, 7, 0, 1, 0));
    expect_start(cyc + 1, "R6");
    step(1);
    chk("R6 length 0 as 1", sample_o, 0);
    pulse_done();

    // R7: invalid selects
    wr(cw(1, 0, 6, 0, 1, 0));
    step(40);
    chk("R7 sel6 still sampling", sample_o, 1);
    wr(cw(1, 0, 6, 0, 0, 0));
    chk("R7 abort no conv", sample_o, 0);
    wr(cw(1, 0, 9, 0, 1, 0));
    pulse_trig(0, 0, "R7");
    step(10);
    chk("R7 sel9 still sampling", sample_o, 1);
    wr(cw(1, 0, 9, 0, 0, 0));
    step(2);
    chk("R7 sel9 no start", conv_start_o, 0);

    // R9: auto-start
    wr(cw(1, 0, 0, 1, 1, 0));
    wr(cw(1, 0, 0, 1, 0, 0));
    expect_start(cyc, "R9");
    pulse_done();
    chk("R9 rearm bit", rd_data_o[1], 1);
    chk("R9 rearm out", sample_o, 1);
    chk("R9 done", rd_data_o[0], 1);
    wr(cw(1, 0, 0, 0, 0, 0));
    expect_start(cyc, "R9");
    pulse_done();

    // R10: completion and software clear on the same edge
    wr(cw(1, 0, 0, 0, 0, 0));
    wr(cw(1, 0, 0, 0, 1, 0));
    wr(cw(1, 0, 0, 0, 0, 0));
    expect_start(cyc, "R10");
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = cw(1, 0, 0, 0, 0, 0); conv_done_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; conv_done_i = 1'b0;
    chk("R10 set wins", rd_data_o[0], 1);

    // R11: idle halt with counter select
    smp_len_i = 5'd6;
    wr(cw(1, 1, 7, 0, 1, 0));
    step(2);
    idle_i = 1'b1;
    step(10);
    chk("R11 halted out", sample_o, 0);
    chk("R11 bit frozen", rd_data_o[1], 1);
    idle_i = 1'b0;
    expect_start(cyc + 4, "R11");
    step(4);
    idle_i = 1'b1;
    pulse_done();
    chk("R11 strobe ignored", rd_data_o[0], 0);
    idle_i = 1'b0;
    pulse_done();
    chk("R11 resumed", rd_data_o[0], 1);
    // R11: stop-in-idle off keeps running
    wr(cw(1, 0, 0, 0, 1, 0));
    idle_i = 1'b1;
    step(1);
    chk("R11 run in idle", sample_o, 1);
    wr(cw(1, 0, 0, 0, 0, 0));
    expect_start(cyc, "R11");
    pulse_done();
    idle_i = 1'b0;

    // R3: disabling mid-sample
    wr(cw(1, 0, 0, 0, 1, 0));
    wr(cw(0, 0, 0, 0, 1, 0));
    chk("R3 out drops", sample_o, 0);
    step(1);
    chk("R3 bit drops", rd_data_o[1], 0);

    step(3);
    chk("R12 scoreboard empty", sb_q.size(), 0);
    finish_run();
  end
endmodule